// File: doc/BRIEF.md
# SHA-256 Four-Round Compression Step

This block advances a SHA-256 working state by four compression rounds per operation. The state is split into two 128-bit halves, each holding four 32-bit lanes. One half holds a, b, c and d, with a in lane 0 and d in lane 3. The other half holds e, f, g and h, with e in lane 0 and h in lane 3. A third 128-bit operand carries four words, each already the sum of a message-schedule word and its round constant. These words are used lane 0 first.

The unit is iterative. A start request on an idle cycle captures the three operands and a mode bit. One round then runs per clock. After the fourth round a one-cycle done pulse marks a registered result. Depending on the mode, the result is the updated abcd half or the updated efgh half. A caller that needs both halves issues the same operands twice, once with each mode. Sixteen such pairs make up a full 64-round compression. Message expansion, padding, constant storage and the final addition into the chaining value are left to the surrounding logic.

Top module: `sha4r_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `result` is all zeros.
- R2: When `start` is 1 and `busy` is 0 at a rising clock edge, the unit captures `abcd_in`, `efgh_in`, `wk_in` and `mode`, and `busy` is 1 after that edge.
- R3: Exactly four rounds run per accepted start. `done` is 1 only in the cycle after the fourth round, which is four clock edges after the accepting edge. `busy` drops at that same edge, and `done` never stays high for two cycles.
- R4: A `start` that arrives while `busy` is 1 has no effect on the running operation, on its result or on the number of done pulses.
- R5: Each round computes T = h + S1(e) + ch + w modulo 2^32. Here S1 is the XOR of e rotated right by 6, 11 and 25 bits, and ch = ((f XOR g) AND e) XOR g. The new e is d + T. The new a is T + S0(a) + maj, where S0 is the XOR of a rotated right by 2, 13 and 22 bits, and maj = (a AND b) OR ((a OR b) AND c).
- R6: Round k (k = 0..3) uses the word in bits [32k+31:32k] of `wk_in`.
- R7: After each round, lanes move up by one in both halves. The new a enters abcd lane 0, old a goes to lane 1, old b to lane 2 and old c to lane 3. Likewise, the new e enters efgh lane 0, and old e, f and g go to lanes 1, 2 and 3.
- R8: With `mode` = 0, `result` is the updated abcd half. With `mode` = 1, it is the updated efgh half. In both cases lane k sits in bits [32k+31:32k].
- R9: `result` changes only at the edge that completes the fourth round, and it holds its value until the next completion.
- R10: Sixteen chained operations using the standard SHA-256 constants, followed by the feed-forward addition, give the digest of the one-block message "abc" (ba7816bf...f20015ad).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, honoured only while idle |
| mode | input | 1 | 0 returns the abcd half, 1 returns the efgh half |
| abcd_in | input | 128 | Working words a..d, a in lane 0 |
| efgh_in | input | 128 | Working words e..h, e in lane 0 |
| wk_in | input | 128 | Four message-plus-constant words, lane 0 used first |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 128 | Registered updated half selected by mode |

## Verification
On every cycle the assertions check the sequencing rules. An idle start is accepted and resets the round counter. While busy, the counter advances by exactly one per cycle no matter what `start` does. `busy` falls only together with a single-cycle `done`, and `result` stays still except at a completing edge. The arithmetic cannot be shown that way, so it rests on the bench's scenarios: a round-by-round model over random and extreme operands in both modes, a mid-operation start with different operands, and the chained "abc" digest, which ties lane order, rotation amounts and the shift direction to the published hash value.

// File: rtl/sha4r_pkg.sv
package sha4r_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned VEC_W  = WORD_W * LANES;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // upper-case sigma on the a word
  function automatic word_t sum_a(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  // upper-case sigma on the e word
  function automatic word_t sum_e(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t pick(input word_t e, input word_t f, input word_t g);
    return ((f ^ g) & e) ^ g;
  endfunction

  function automatic word_t vote(input word_t a, input word_t b, input word_t c);
    return (a & b) | ((a | b) & c);
  endfunction
endpackage

// File: rtl/sha4r_round.sv
module sha4r_round
  import sha4r_pkg::*;
(
  input  logic [VEC_W-1:0] abcd,
  input  logic [VEC_W-1:0] efgh,
  input  word_t            w,
  output logic [VEC_W-1:0] abcd_nx,
  output logic [VEC_W-1:0] efgh_nx
);
  word_t a, b, c, d, e, f, g, h;
  word_t t_mix, a_new, e_new;

  assign a = abcd[0*WORD_W +: WORD_W];
  assign b = abcd[1*WORD_W +: WORD_W];
  assign c = abcd[2*WORD_W +: WORD_W];
  assign d = abcd[(LANES-1)*WORD_W +: WORD_W];
  assign e = efgh[0*WORD_W +: WORD_W];
  assign f = efgh[1*WORD_W +: WORD_W];
  assign g = efgh[2*WORD_W +: WORD_W];
  assign h = efgh[(LANES-1)*WORD_W +: WORD_W];

  always_comb begin
    t_mix = h + sum_e(e) + pick(e, f, g) + w;
    e_new = d + t_mix;
    a_new = t_mix + sum_a(a) + vote(a, b, c);
  end

  assign abcd_nx[0 +: WORD_W] = a_new;
  assign efgh_nx[0 +: WORD_W] = e_new;

  for (genvar l = 1; l < LANES; l++) begin : g_shift
    assign abcd_nx[l*WORD_W +: WORD_W] = abcd[(l-1)*WORD_W +: WORD_W];
    assign efgh_nx[l*WORD_W +: WORD_W] = efgh[(l-1)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/sha4r_seq.sv
module sha4r_seq #(
  parameter int unsigned STEPS = 4,
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o,
  output logic [CNT_W-1:0] step_o
);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, last;

  always_comb begin
    accept = start & ~busy_q;
    last   = busy_q & (cnt_q == LAST_STEP);
    busy_d = accept | (busy_q & ~last);
    done_d = last;
    cnt_d  = cnt_q;
    if (accept)      cnt_d = '0;
    else if (busy_q) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign accept_o = accept;
  assign busy_o   = busy_q;
  assign last_o   = last;
  assign done_o   = done_q;
  assign step_o   = cnt_q;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && cnt_q == '0));
  assert_ignore_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
endmodule

// File: rtl/sha4r_unit.sv
module sha4r_unit
  import sha4r_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [VEC_W-1:0] abcd_in,
  input  logic [VEC_W-1:0] efgh_in,
  input  logic [VEC_W-1:0] wk_in,
  output logic             busy,
  output logic             done,
  output logic [VEC_W-1:0] result
);
  localparam int unsigned STEP_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              accept, last;
  logic [STEP_W-1:0] step;
  logic [VEC_W-1:0]  abcd_q, abcd_d, efgh_q, efgh_d, wk_q, wk_d, res_q, res_d;
  logic [VEC_W-1:0]  abcd_nx, efgh_nx;
  logic              mode_q, mode_d;
  word_t             wk_lane [LANES];
  word_t             wk_cur;

  sha4r_seq #(.STEPS(LANES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last),
    .done_o   (done),
    .step_o   (step)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_wk
    assign wk_lane[l] = wk_q[l*WORD_W +: WORD_W];
  end
  assign wk_cur = wk_lane[step];

  sha4r_round u_round (
    .abcd    (abcd_q),
    .efgh    (efgh_q),
    .w       (wk_cur),
    .abcd_nx (abcd_nx),
    .efgh_nx (efgh_nx)
  );

  always_comb begin
    abcd_d = abcd_q;
    efgh_d = efgh_q;
    wk_d   = wk_q;
    mode_d = mode_q;
    res_d  = res_q;
    if (accept) begin
      abcd_d = abcd_in;
      efgh_d = efgh_in;
      wk_d   = wk_in;
      mode_d = mode;
    end else if (busy) begin
      abcd_d = abcd_nx;
      efgh_d = efgh_nx;
    end
    if (last) res_d = mode_q ? efgh_nx : abcd_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abcd_q <= '0;
      efgh_q <= '0;
      wk_q   <= '0;
      mode_q <= 1'b0;
      res_q  <= '0;
    end else begin
      abcd_q <= abcd_d;
      efgh_q <= efgh_d;
      wk_q   <= wk_d;
      mode_q <= mode_d;
      res_q  <= res_d;
    end
  end

  assign result = res_q;

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(result));
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/sha4r_unit_test.sv
`timescale 1ns/1ps
module sha4r_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, mode;
  logic [127:0] abcd_in, efgh_in, wk_in;
  logic         busy, done;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;

  sha4r_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .abcd_in(abcd_in), .efgh_in(efgh_in), .wk_in(wk_in),
    .busy(busy), .done(done), .result(result)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // expected four-round update of both halves, written from R5..R7
  task automatic model(input logic [127:0] p, input logic [127:0] q,
                       input logic [127:0] w,
                       output logic [127:0] po, output logic [127:0] qo);
    logic [31:0] a, b, c, d, e, f, g, h, t, s1, s0, ch, mj;
    {d, c, b, a} = p;
    {h, g, f, e} = q;
    for (int k = 0; k < 4; k++) begin
      s1 = rr(e, 6) ^ rr(e, 11) ^ rr(e, 25);
      s0 = rr(a, 2) ^ rr(a, 13) ^ rr(a, 22);
      ch = (e & f) | (~e & g);
      mj = (a & b) ^ (a & c) ^ (b & c);
      t  = h + s1 + ch + w[32*k +: 32];
      h = g; g = f; f = e; e = d + t;
      d = c; c = b; b = a; a = t + s0 + mj;
    end
    po = {d, c, b, a};
    qo = {h, g, f, e};
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one operation; returns cycles from start drive to done seen
  task automatic run_op(input logic [127:0] p, input logic [127:0] q,
                        input logic [127:0] w, input logic m,
                        output logic [127:0] res, output int n);
    @(negedge clk);
    abcd_in = p; efgh_in = q; wk_in = w; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    res = result;
  endtask

  logic [31:0] K [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] p, q, w, ep, eq, r, r2, held;
    int n;
    logic [31:0] W [64];
    logic [31:0] H [8];
    logic [31:0] s0w, s1w;
    logic [255:0] dig;

    rst_n = 1'b0; start = 1'b0; mode = 1'b0;
    abcd_in = '0; efgh_in = '0; wk_in = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 reset state",
          {126'd0, busy, done} | result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after release",
          {126'd0, busy, done} | result, '0);

    // R2 busy after accepting edge; R3 latency and single pulse
    p = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    q = {32'h88888888, 32'h77777777, 32'h66666666, 32'h55555555};
    w = {32'hdddddddd, 32'hcccccccc, 32'hbbbbbbbb, 32'haaaaaaaa};
    @(negedge clk);
    abcd_in = p; efgh_in = q; wk_in = w; mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", {127'd0, busy}, 128'd1);
    n = 1;
    while (!done && n < 20) begin @(negedge clk); n++; end
    check(n == 5, "R3 done four edges after accept", 128'(n), 128'd5);
    check(busy == 1'b0, "R3 busy low with done", {127'd0, busy}, 128'd0);
    model(p, q, w, ep, eq);
    check(result == ep, "R5 R7 R8 mode0 abcd result", result, ep);
    @(negedge clk);
    check(done == 1'b0, "R3 done single cycle", {127'd0, done}, 128'd0);

    // R8 mode 1 returns efgh
    run_op(p, q, w, 1'b1, r, n);
    check(r == eq, "R8 mode1 efgh result", r, eq);

    // R6 lane order: reversing wk lanes must follow the model
    w = {32'haaaaaaaa, 32'hbbbbbbbb, 32'hcccccccc, 32'hdddddddd};
    model(p, q, w, ep, eq);
    run_op(p, q, w, 1'b0, r, n);
    check(r == ep, "R6 wk lane order abcd", r, ep);
    run_op(p, q, w, 1'b1, r, n);
    check(r == eq, "R6 wk lane order efgh", r, eq);

    // extremes: zeros and ones, both modes (R5 carries wrap)
    for (int x = 0; x < 4; x++) begin
      p = (x[0]) ? '1 : '0;
      q = (x[1]) ? '1 : '0;
      w = '1;
      model(p, q, w, ep, eq);
      run_op(p, q, w, 1'b0, r, n);
      check(r == ep, "R5 extreme operands abcd", r, ep);
      run_op(p, q, w, 1'b1, r, n);
      check(r == eq, "R5 extreme operands efgh", r, eq);
    end

    // random sweep (R5 R7 R8), and latency every time (R3)
    for (int i = 0; i < 40; i++) begin
      p = {$urandom, $urandom, $urandom, $urandom};
      q = {$urandom, $urandom, $urandom, $urandom};
      w = {$urandom, $urandom, $urandom, $urandom};
      model(p, q, w, ep, eq);
      run_op(p, q, w, i[0], r, n);
      check(r == (i[0] ? eq : ep), "R5 R7 R8 random operands", r, i[0] ? eq : ep);
      check(n == 5, "R3 latency random", 128'(n), 128'd5);
    end

    // R4 start while busy is ignored
    p = {32'h01234567, 32'h89abcdef, 32'hfedcba98, 32'h76543210};
    q = {32'h0f0f0f0f, 32'hf0f0f0f0, 32'h00ff00ff, 32'hff00ff00};
    w = {32'h13579bdf, 32'h2468ace0, 32'h11223344, 32'h55667788};
    model(p, q, w, ep, eq);
    @(negedge clk);
    abcd_in = p; efgh_in = q; wk_in = w; mode = 1'b0; start = 1'b1;
    @(negedge clk);
    abcd_in = ~p; efgh_in = ~q; wk_in = ~w; mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 2;
    while (!done && n < 20) begin @(negedge clk); n++; end
    check(n == 5, "R4 busy start keeps latency", 128'(n), 128'd5);
    check(result == ep, "R4 busy start keeps operands", result, ep);
    n = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (done) n++;
    end
    check(n == 0, "R4 no extra done pulse", 128'(n), 128'd0);

    // R9 result holds while idle with changing inputs
    held = result;
    for (int c = 0; c < 6; c++) begin
      abcd_in = {$urandom, $urandom, $urandom, $urandom};
      mode = ~mode;
      @(negedge clk);
    end
    check(result == held, "R9 result held while idle", result, held);
    // R9 result holds during an operation until completion
    @(negedge clk);
    abcd_in = p; efgh_in = q; wk_in = w; mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(result == held, "R9 result held mid operation", result, held);
    while (!done) @(negedge clk);
    check(result == eq, "R9 result updated at completion", result, eq);

    // R10 chained compression of "abc"
    for (int t = 0; t < 16; t++) W[t] = 32'h0;
    W[0] = 32'h61626380;
    W[15] = 32'h00000018;
    for (int t = 16; t < 64; t++) begin
      s0w = rr(W[t-15], 7) ^ rr(W[t-15], 18) ^ (W[t-15] >> 3);
      s1w = rr(W[t-2], 17) ^ rr(W[t-2], 19) ^ (W[t-2] >> 10);
      W[t] = W[t-16] + s0w + W[t-7] + s1w;
    end
    H = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
          32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    p = {H[3], H[2], H[1], H[0]};
    q = {H[7], H[6], H[5], H[4]};
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 4; k++) w[32*k +: 32] = K[4*s+k] + W[4*s+k];
      run_op(p, q, w, 1'b0, r, n);
      run_op(p, q, w, 1'b1, r2, n);
      p = r;
      q = r2;
    end
    for (int k = 0; k < 4; k++) begin
      H[k]   = H[k]   + p[32*k +: 32];
      H[k+4] = H[k+4] + q[32*k +: 32];
    end
    dig = {H[0], H[1], H[2], H[3], H[4], H[5], H[6], H[7]};
    check(dig == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
          "R10 abc digest high", dig[255:128],
          128'hba7816bf8f01cfea414140de5dae2223);
    check(dig[127:0] == 128'hb00361a396177a9cb410ff61f20015ad,
          "R10 abc digest low", dig[127:0],
          128'hb00361a396177a9cb410ff61f20015ad);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule